// File: doc/BRIEF.md
# ATM Cell Header Sideband Inserter

This block sits in a byte-serial ATM cell stream and rewrites a few bits of each cell's header and user-defined octet (UDF), so that per-cell side information travels with the cell. Three values can be carried: a 3-bit framer port number, a 5-bit AAL channel number (the first timeslot of the channel), and a flag that marks a cell whose HEC could not be corrected. All other bits, including the whole 48-byte payload, pass through untouched. The output stream keeps the input's timing and is delayed by exactly one register stage.

A cell is 53 bytes, and the bytes come in this order: header bytes 1 to 4, then the UDF byte, then the payload. The standard UNI layout applies: byte 1 holds GFC[3:0] in bits 7:4 and VPI[7:4] in bits 3:0. Byte 2 holds VPI[3:0] and VCI[15:12]. Byte 3 holds VCI[11:4]. Byte 4 holds VCI[3:0] in bits 7:4, followed by PT and CLP.

A byte counter restarts on each start-of-cell byte. The sideband inputs are sampled on that first byte and held for the rest of the cell. A 3-bit mapping code decides where the port number goes. The port number is written only when the port-insertion enable is set, which software sets when the interface runs as a level 1 or single-PHY level 2 link. The HEC flag is written only when errored cells are kept and the port's cell-discard bit is clear. HEC recomputation and discard decisions are not performed here.

Top module: `atm_sb_inserter`

## Requirements
- R1: Every input byte appears on the output exactly one clock later. `out_valid` and `out_sop` are `in_valid` and `in_sop` delayed by one cycle.
- R2: With insertion enabled, mapping code 1 writes the port number into byte 1 bits 7:5 (GFC[3:1]), and code 2 writes it into byte 1 bits 3:1 (VPI[7:5]).
- R3: With insertion enabled, mapping code 3 writes the port number into byte 2 bits 3:1 (VCI[15:13]), and code 4 writes it into byte 3 bits 3:1 (VCI[7:5]).
- R4: With insertion enabled, mapping code 5 writes the port number into UDF bits 2:0.
- R5: Mapping codes 0, 6 and 7, or a cleared `cfg_port_en`, disable port-number insertion. With AAL mode and HEC flagging also off, the block is fully transparent.
- R6: With `cfg_aal` set, the channel number is written into VCI[4:0]. Channel bit 4 goes to byte 3 bit 0, and channel bits 3:0 go to byte 4 bits 7:4.
- R7: UDF bit 7 is replaced by the HEC error flag only when `cfg_hec_keep` is 1 and `cfg_cell_disc` is 0. Otherwise UDF bit 7 passes through unchanged.
- R8: UDF bit 5, the discard-policy select, is never altered in any configuration.
- R9: Payload bytes (index 5 to 52), and valid bytes that are not preceded by a start-of-cell since reset or since the end of the last cell, pass through unchanged.
- R10: The sideband values (port, channel, HEC flag) used for a whole cell are the ones present on its start-of-cell byte. Later changes within the cell have no effect.
- R11: While reset is held, `out_valid`, `out_sop` and `out_data` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input byte valid |
| in_sop | input | 1 | Marks the first byte of a cell (qualified by in_valid) |
| in_data | input | 8 | Input cell byte |
| sb_port | input | 3 | Framer port number for the cell |
| sb_chan | input | 5 | AAL channel number for the cell |
| sb_hec_err | input | 1 | Uncorrectable HEC error flag for the cell |
| cfg_map | input | 3 | Port-number location code (1..5; other codes disable) |
| cfg_port_en | input | 1 | Enables port-number insertion |
| cfg_aal | input | 1 | AAL mode: insert channel number into VCI[4:0] |
| cfg_hec_keep | input | 1 | Errored cells are kept (not discarded) |
| cfg_cell_disc | input | 1 | Per-port cell-discard bit |
| out_valid | output | 1 | Output byte valid |
| out_sop | output | 1 | Output first byte of a cell |
| out_data | output | 8 | Output cell byte with sideband inserted |

## Verification
Four things are checked on every cycle: the one-cycle latency of valid and start-of-cell, the restart of the byte counter at each start-of-cell, the pass-through of payload bytes and of UDF bit 5, and the untouched UDF bit 7 whenever flagging is not allowed. A full transparency check also runs every cycle when all insertion is off. The exact position of the port number for each mapping code, the VCI bit split of the channel number, and the value of the HEC flag can only be shown by the bench's directed cells. The same holds for holding the sideband values from the first byte of a cell and for leaving bytes outside any cell alone.

// File: rtl/atm_sb_pkg.sv
package atm_sb_pkg;
  localparam int BYTE_W = 8;
  localparam int PORT_W = 3;
  localparam int CHAN_W = 5;
  localparam int MAP_W  = 3;

  // Byte positions inside a cell; rewriting depends on them.
  localparam int POS_H1  = 0;
  localparam int POS_H2  = 1;
  localparam int POS_H3  = 2;
  localparam int POS_H4  = 3;
  localparam int POS_UDF = 4;

  // Port-number location codes
  localparam logic [MAP_W-1:0] MAP_GFC     = 3'd1;
  localparam logic [MAP_W-1:0] MAP_VPI_HI  = 3'd2;
  localparam logic [MAP_W-1:0] MAP_VCI_TOP = 3'd3;
  localparam logic [MAP_W-1:0] MAP_VCI_MID = 3'd4;
  localparam logic [MAP_W-1:0] MAP_UDF     = 3'd5;

  typedef struct packed {
    logic [PORT_W-1:0] port;
    logic [CHAN_W-1:0] chan;
    logic              hef;
  } sideband_t;
endpackage

// File: rtl/atm_sb_cellpos.sv
module atm_sb_cellpos #(
  parameter int CELL_BYTES = 53,
  localparam int CNT_W = $clog2(CELL_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic             in_sop,
  output logic [CNT_W-1:0] idx
);
  localparam logic [CNT_W-1:0] IDLE = CNT_W'(CELL_BYTES);

  logic [CNT_W-1:0] cnt;
  logic             sop;

  assign sop = in_valid && in_sop;
  assign idx = sop ? '0 : cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= IDLE;
    end else if (in_valid) begin
      if (sop)              cnt <= CNT_W'(1);
      else if (cnt != IDLE) cnt <= cnt + CNT_W'(1);
    end
  end

  AST_SOP_RESTART: assert property (@(posedge clk) disable iff (rst)
    sop |=> cnt == CNT_W'(1)); // R10
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt <= IDLE); // R9
endmodule

// File: rtl/atm_sb_rewrite.sv
module atm_sb_rewrite
  import atm_sb_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic [CNT_W-1:0]  idx,
  input  logic [BYTE_W-1:0] din,
  input  sideband_t         sb,
  input  logic [MAP_W-1:0]  map_code,
  input  logic              port_en,
  input  logic              aal_en,
  input  logic              hef_en,
  output logic [BYTE_W-1:0] dout
);
  logic port_on;

  always_comb begin
    port_on = port_en && (map_code >= MAP_GFC) && (map_code <= MAP_UDF);
    dout = din;
    case (idx)
      CNT_W'(POS_H1): begin
        if (port_on && map_code == MAP_GFC)    dout[7:5] = sb.port;
        if (port_on && map_code == MAP_VPI_HI) dout[3:1] = sb.port;
      end
      CNT_W'(POS_H2): begin
        if (port_on && map_code == MAP_VCI_TOP) dout[3:1] = sb.port;
      end
      CNT_W'(POS_H3): begin
        if (port_on && map_code == MAP_VCI_MID) dout[3:1] = sb.port;
        if (aal_en) dout[0] = sb.chan[4];
      end
      CNT_W'(POS_H4): begin
        if (aal_en) dout[7:4] = sb.chan[3:0];
      end
      CNT_W'(POS_UDF): begin
        if (port_on && map_code == MAP_UDF) dout[2:0] = sb.port;
        if (hef_en) dout[7] = sb.hef;
      end
      default: dout = din;
    endcase
  end
endmodule

// File: rtl/atm_sb_inserter.sv
module atm_sb_inserter
  import atm_sb_pkg::*;
#(
  parameter int CELL_BYTES = 53,
  localparam int CNT_W = $clog2(CELL_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              in_sop,
  input  logic [BYTE_W-1:0] in_data,
  input  logic [PORT_W-1:0] sb_port,
  input  logic [CHAN_W-1:0] sb_chan,
  input  logic              sb_hec_err,
  input  logic [MAP_W-1:0]  cfg_map,
  input  logic              cfg_port_en,
  input  logic              cfg_aal,
  input  logic              cfg_hec_keep,
  input  logic              cfg_cell_disc,
  output logic              out_valid,
  output logic              out_sop,
  output logic [BYTE_W-1:0] out_data
);
  logic [CNT_W-1:0]  idx;
  sideband_t         sb_live, sb_q, sb_eff;
  logic              sop, hef_en;
  logic [BYTE_W-1:0] new_byte;

  assign sop     = in_valid && in_sop;
  assign sb_live = '{port: sb_port, chan: sb_chan, hef: sb_hec_err};
  assign sb_eff  = sop ? sb_live : sb_q;
  assign hef_en  = cfg_hec_keep && !cfg_cell_disc;

  atm_sb_cellpos #(.CELL_BYTES(CELL_BYTES)) u_pos (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sop(in_sop), .idx(idx)
  );

  atm_sb_rewrite #(.CNT_W(CNT_W)) u_rw (
    .idx(idx), .din(in_data), .sb(sb_eff), .map_code(cfg_map),
    .port_en(cfg_port_en), .aal_en(cfg_aal), .hef_en(hef_en), .dout(new_byte)
  );

  always_ff @(posedge clk) begin
    if (rst)      sb_q <= '0;
    else if (sop) sb_q <= sb_live;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_sop   <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      out_sop   <= sop;
      out_data  <= new_byte;
    end
  end

  AST_VALID_LAT: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (out_valid == $past(in_valid)) && (out_sop == $past(sop))); // R1
  AST_PAYLOAD_PASS: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && $past(in_valid && idx > CNT_W'(POS_UDF)) |-> out_data == $past(in_data)); // R9
  AST_BIT5_KEEP: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && $past(in_valid) |-> (($past(idx) != CNT_W'(POS_UDF)) || (out_data[5] == $past(in_data[5])))); // R8
  AST_HEF_BLOCKED: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && $past(in_valid && idx == CNT_W'(POS_UDF) && !hef_en) |-> out_data[7] == $past(in_data[7])); // R7
  AST_ALL_OFF_PASS: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && $past(!cfg_port_en && !cfg_aal && !hef_en) |-> out_data == $past(in_data)); // R5
endmodule

// File: tb/atm_sb_inserter_bench.sv
module atm_sb_inserter_bench;
  localparam int NB = 53;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0, in_sop = 1'b0;
  logic [7:0] in_data = '0;
  logic [2:0] sb_port = '0;
  logic [4:0] sb_chan = '0;
  logic       sb_hec_err = 1'b0;
  logic [2:0] cfg_map = '0;
  logic       cfg_port_en = 1'b0, cfg_aal = 1'b0, cfg_hec_keep = 1'b0, cfg_cell_disc = 1'b0;
  logic       out_valid, out_sop;
  logic [7:0] out_data;

  int tests = 0, fails = 0;
  bit done = 0;
  logic [7:0] hdr [5];

  always #5 clk = ~clk;

  atm_sb_inserter u_atm_sb_inserter (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sop(in_sop), .in_data(in_data),
    .sb_port(sb_port), .sb_chan(sb_chan), .sb_hec_err(sb_hec_err),
    .cfg_map(cfg_map), .cfg_port_en(cfg_port_en), .cfg_aal(cfg_aal),
    .cfg_hec_keep(cfg_hec_keep), .cfg_cell_disc(cfg_cell_disc),
    .out_valid(out_valid), .out_sop(out_sop), .out_data(out_data)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [7:0] exp_byte(input int i, input logic [7:0] b,
      input logic [2:0] p, input logic [4:0] c, input logic he);
    logic [7:0] r = b;
    bit on = cfg_port_en && cfg_map >= 3'd1 && cfg_map <= 3'd5;
    case (i)
      0: begin
        if (on && cfg_map == 3'd1) r[7:5] = p;
        if (on && cfg_map == 3'd2) r[3:1] = p;
      end
      1: if (on && cfg_map == 3'd3) r[3:1] = p;
      2: begin
        if (on && cfg_map == 3'd4) r[3:1] = p;
        if (cfg_aal) r[0] = c[4];
      end
      3: if (cfg_aal) r[7:4] = c[3:0];
      4: begin
        if (on && cfg_map == 3'd5) r[2:0] = p;
        if (cfg_hec_keep && !cfg_cell_disc) r[7] = he;
      end
      default: r = b;
    endcase
    return r;
  endfunction

  function automatic logic [7:0] in_byte(input int i);
    return (i < 5) ? hdr[i] : 8'(i * 7 + 3);
  endfunction

  // Sends one cell; checks header bytes, payload, and start-of-cell timing.
  task automatic run_cell(input string req, input bit change_mid);
    logic [7:0] got [NB];
    logic       gsop [NB];
    logic       gval [NB];
    logic [2:0] p = sb_port;
    logic [4:0] c = sb_chan;
    logic       he = sb_hec_err;
    int bad = 0, sop_bad = 0;
    for (int i = 0; i <= NB; i++) begin
      @(negedge clk);
      if (i > 0) begin
        got[i-1] = out_data; gsop[i-1] = out_sop; gval[i-1] = out_valid;
      end
      if (i == 1 && change_mid) begin
        sb_port = ~p; sb_chan = ~c; sb_hec_err = ~he;
      end
      if (i < NB) begin
        in_valid = 1'b1; in_sop = (i == 0); in_data = in_byte(i);
      end else begin
        in_valid = 1'b0; in_sop = 1'b0;
      end
    end
    for (int i = 0; i < 5; i++)
      chk(req, {24'd0, got[i]}, {24'd0, exp_byte(i, hdr[i], p, c, he)});
    for (int i = 5; i < NB; i++) if (got[i] !== in_byte(i)) bad++;
    chk("R9 payload mismatches", bad, 0);
    for (int i = 0; i < NB; i++) if (gsop[i] !== (i == 0) || gval[i] !== 1'b1) sop_bad++;
    chk("R1 sop/valid timing", sop_bad, 0);
    sb_port = p; sb_chan = c; sb_hec_err = he;
  endtask

  task automatic set_hdr(input logic [7:0] v);
    for (int i = 0; i < 5; i++) hdr[i] = v;
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R11 out_valid", out_valid, 0);
    chk("R11 out_sop", out_sop, 0);
    chk("R11 out_data", out_data, 0);
    rst = 1'b0;
  endtask

  task automatic t_map;
    cfg_port_en = 1; cfg_aal = 0; cfg_hec_keep = 0; sb_port = 3'b101;
    for (int m = 1; m <= 5; m++) begin
      cfg_map = 3'(m);
      set_hdr(8'h00); run_cell(m <= 2 ? "R2" : (m <= 4 ? "R3" : "R4"), 0);
      sb_port = 3'b010;
      set_hdr(8'hFF); run_cell(m <= 2 ? "R2" : (m <= 4 ? "R3" : "R4"), 0);
      sb_port = 3'b101;
    end
  endtask

  task automatic t_map_off;
    cfg_port_en = 1; cfg_aal = 0; cfg_hec_keep = 0; sb_port = 3'b111;
    set_hdr(8'h00);
    cfg_map = 3'd0; run_cell("R5 code0", 0);
    cfg_map = 3'd6; run_cell("R5 code6", 0);
    cfg_map = 3'd7; run_cell("R5 code7", 0);
    cfg_map = 3'd1; cfg_port_en = 0; run_cell("R5 port_en low", 0);
  endtask

  task automatic t_aal;
    cfg_port_en = 1; cfg_map = 3'd4; cfg_aal = 1; cfg_hec_keep = 0;
    sb_port = 3'b011; sb_chan = 5'h16;
    set_hdr(8'h00); run_cell("R6", 0);
    sb_chan = 5'h09; set_hdr(8'hFF); run_cell("R6", 0);
    cfg_aal = 0;
  endtask

  task automatic t_hef;
    cfg_port_en = 0; cfg_aal = 0;
    for (int k = 0; k < 4; k++) begin
      cfg_hec_keep = k[0]; cfg_cell_disc = k[1];
      sb_hec_err = 1; set_hdr(8'h00); run_cell("R7", 0);
      sb_hec_err = 0; set_hdr(8'hFF); run_cell("R7", 0);
    end
    cfg_cell_disc = 0; cfg_hec_keep = 1;
  endtask

  task automatic t_bit5;
    logic [7:0] g;
    cfg_port_en = 1; cfg_map = 3'd5; cfg_hec_keep = 1; cfg_cell_disc = 0;
    sb_port = 3'b111; sb_hec_err = 1;
    set_hdr(8'h20); run_cell("R8", 0);
    sb_port = 3'b000; sb_hec_err = 0;
    set_hdr(8'hDF);
    for (int i = 0; i <= 5; i++) begin
      @(negedge clk);
      if (i == 5) begin
        g = out_data;
        chk("R8 udf bit5", g[5], 0);
      end
      in_valid = 1; in_sop = (i == 0); in_data = hdr[i < 5 ? i : 0];
    end
    for (int i = 6; i <= NB; i++) begin
      @(negedge clk);
      if (i < NB) begin in_valid = 1; in_sop = 0; in_data = in_byte(i); end
      else in_valid = 0;
    end
  endtask

  task automatic t_hold;
    cfg_port_en = 1; cfg_map = 3'd5; cfg_aal = 1; cfg_hec_keep = 1; cfg_cell_disc = 0;
    sb_port = 3'b110; sb_chan = 5'h1B; sb_hec_err = 1;
    set_hdr(8'h00); run_cell("R10", 1);
  endtask

  task automatic t_outside;
    cfg_port_en = 1; cfg_map = 3'd1; cfg_aal = 1; cfg_hec_keep = 1; cfg_cell_disc = 0;
    sb_port = 3'b111; sb_chan = 5'h1F; sb_hec_err = 1;
    rst = 1; @(negedge clk); @(negedge clk); rst = 0;
    for (int i = 0; i <= 6; i++) begin
      @(negedge clk);
      if (i > 0) chk("R9 no-sop byte", out_data, 8'(i * 16 + 1 - 16));
      if (i < 6) begin in_valid = 1; in_sop = 0; in_data = 8'(i * 16 + 1); end
      else in_valid = 0;
    end
  endtask

  initial begin
    t_reset();
    t_map();
    t_map_off();
    t_aal();
    t_hef();
    t_bit5();
    t_hold();
    t_outside();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      tests++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule